// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a small programmable logic device built from two planes. A programmable AND plane forms 64 product terms. Each term can take any signal in true or complemented form. The signals are eight dedicated logic inputs and eight feedback lines, one from each output cell. A fixed OR plane then gives every output cell its own private group of eight product terms. Each output cell can be configured as a clocked register or as a purely combinational path. It also has a selectable output polarity. In combinational mode, the cell can use its first product term as a per-pin output enable. It can also release the pin entirely so that the pin serves as an input.

The whole personality of the device is one static configuration vector of 2080 bits. The first 2048 bits are the AND-plane fuse map. The last 32 bits hold the 4 mode bits of each output cell. Three-state pins are split into three signals: a driven value, a separate enable, and a pin-level input that carries the value seen on the pad. The clock and the global output-enable are separate inputs. They control the cells that are in registered mode.

Top module: `pal_array`

## Requirements
- R1: Product term t (0..63) occupies configuration bits t*32 .. t*32+31. Column 2*s is the true form of signal s and column 2*s+1 is its complement. Signals 0..7 are `in_pins[7:0]` and signals 8..15 are the feedback lines of cells 0..7. A bit at 1 (intact fuse) connects its literal into the AND. A term with no intact fuse evaluates to 1.
- R2: A product term with both the true and the complement column of the same signal intact evaluates to 0, whatever the inputs.
- R3: Cell m ORs product terms m*8 .. m*8+7, all eight of them, unless R9 removes term m*8.
- R4: Cell m's control field sits at bits 2048+4*m .. 2048+4*m+3. Its bit 1 selects polarity: 1 drives the sum unchanged and 0 drives its complement.
- R5: Control bit 0 at 1 makes the cell registered. `io_out[m]` then shows a register that loads the cell's polarity-adjusted sum on each rising edge of `clk` and holds it between edges. A low `rst_n` clears it to 0 at once.
- R6: A registered cell drives `io_oe[m]` as the inverse of `oe_glob_n`.
- R7: The feedback line of a registered cell is its register output, and `io_in[m]` has no effect on it.
- R8: The feedback line of a combinational cell (control bit 0 at 0) is the pin value `io_in[m]`. `io_out[m]` follows the polarity-adjusted sum with no clock.
- R9: In a combinational cell, control bit 2 at 1 makes term m*8 the pin enable (`io_oe[m]` equals that term) and removes it from the sum. With the bit at 0, all eight terms are summed and `io_oe[m]` is 1.
- R10: In a combinational cell, control bit 3 at 1 holds `io_oe[m]` at 0 while `io_out[m]` still carries the sum. A registered cell ignores control bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registered cells (rising edge) |
| rst_n | input | 1 | Asynchronous active-low clear of the cell registers |
| cfg | input | 2080 | Static configuration: fuse map then per-cell control |
| in_pins | input | 8 | Dedicated logic inputs (signals 0..7) |
| oe_glob_n | input | 1 | Active-low output enable for registered cells |
| io_in | input | 8 | Value seen on each bidirectional pin |
| io_out | output | 8 | Value each cell drives toward its pin |
| io_oe | output | 8 | Per-pin drive enable |

## Verification
The bench targets the following corner cases. It checks terms whose true and complement columns are both intact; a plane that skipped this check would let such a term turn on when the other literals match. It checks that blank terms read as 1. It checks that all eight terms of a cell reach its OR; a cell that dropped one would miss the inputs that only that term decodes. It covers the first term's dual role. When that term doubles as the enable, it must leave the sum, and a cell that kept it in would turn on when only the enable term is true. When the term is not the enable, it must stay in the sum. Feedback source is checked by driving the pin input opposite to the register. A registered cell that read its pin would then stop toggling in the expected pattern. Pseudo-random fuse maps and control fields are swept across all cell modes and compared cycle by cycle with an arithmetic model of the requirements.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Number of control bits per output cell.
    localparam int MC_CTRL_BITS = 4;

    // Control field of one output cell, bit 0 is the LSB.
    typedef struct packed {
        logic in_only;     // bit 3: combinational pin released (input use)
        logic oe_term;     // bit 2: first term acts as pin enable
        logic active_high; // bit 1: 1 = sum unchanged, 0 = complemented
        logic registered;  // bit 0: 1 = clocked cell
    } mc_ctrl_t;

endpackage

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter  int N_SIG = 16,
    parameter  int N_PT  = 64,
    localparam int N_COL = 2 * N_SIG
) (
    input  logic [N_SIG-1:0]      sig,
    input  logic [N_PT*N_COL-1:0] fuse,
    output logic [N_PT-1:0]       pterm
);

    // Literal columns: even = true form, odd = complement.
    logic [N_COL-1:0] lit;

    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
        assign lit[2*s]   = sig[s];
        assign lit[2*s+1] = ~sig[s];
    end

    // A blown fuse forces its column to 1 so it drops out of the AND.
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        assign pterm[t] = &(lit | ~fuse[t*N_COL +: N_COL]);
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
#(
    parameter int PT_PER_MC = 8
) (
    input  mc_ctrl_t               ctrl,
    input  logic [PT_PER_MC-1:0]   pt,
    output logic                   val,
    output logic                   oe
);

    logic [PT_PER_MC-1:0] sum_mask;
    logic                 sum;

    always_comb begin
        sum_mask = '1;
        if (!ctrl.registered && ctrl.oe_term) begin
            sum_mask[0] = 1'b0;
        end
        sum = |(pt & sum_mask);
        val = ctrl.active_high ? sum : ~sum;

        if (ctrl.in_only) begin
            oe = 1'b0;
        end else if (ctrl.oe_term) begin
            oe = pt[0];
        end else begin
            oe = 1'b1;
        end
    end

endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter  int N_DIN      = 8,
    parameter  int N_MC       = 8,
    parameter  int PT_PER_MC  = 8,
    localparam int N_SIG      = N_DIN + N_MC,
    localparam int N_COL      = 2 * N_SIG,
    localparam int N_PT       = N_MC * PT_PER_MC,
    localparam int ARRAY_BITS = N_PT * N_COL,
    localparam int CFG_W      = ARRAY_BITS + N_MC * MC_CTRL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [N_DIN-1:0]  in_pins,
    input  logic              oe_glob_n,
    input  logic [N_MC-1:0]   io_in,
    output logic [N_MC-1:0]   io_out,
    output logic [N_MC-1:0]   io_oe
);

    typedef struct packed {
        logic [N_MC-1:0] q;
    } pal_state_t;

    pal_state_t       st_d, st_q;
    mc_ctrl_t         ctrl [N_MC];
    logic [N_MC-1:0]  fb;
    logic [N_MC-1:0]  mc_val;
    logic [N_MC-1:0]  comb_oe;
    logic [N_SIG-1:0] sig;
    logic [N_PT-1:0]  pterm;

    // Feedback source: register output or pin, chosen per cell.
    always_comb begin
        for (int m = 0; m < N_MC; m++) begin
            fb[m] = ctrl[m].registered ? st_q.q[m] : io_in[m];
        end
    end

    assign sig = {fb, in_pins};

    pal_and_plane #(
        .N_SIG (N_SIG),
        .N_PT  (N_PT)
    ) u_and (
        .sig   (sig),
        .fuse  (cfg[ARRAY_BITS-1:0]),
        .pterm (pterm)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        assign ctrl[m] = mc_ctrl_t'(cfg[ARRAY_BITS + m*MC_CTRL_BITS +: MC_CTRL_BITS]);

        pal_macrocell #(
            .PT_PER_MC (PT_PER_MC)
        ) u_mc (
            .ctrl (ctrl[m]),
            .pt   (pterm[m*PT_PER_MC +: PT_PER_MC]),
            .val  (mc_val[m]),
            .oe   (comb_oe[m])
        );
    end

    // Next state and pin outputs.
    always_comb begin
        st_d   = st_q;
        st_d.q = mc_val;
        for (int m = 0; m < N_MC; m++) begin
            if (ctrl[m].registered) begin
                io_out[m] = st_q.q[m];
                io_oe[m]  = ~oe_glob_n;
            end else begin
                io_out[m] = mc_val[m];
                io_oe[m]  = comb_oe[m];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk
    import pal_pkg::*;
#(
    parameter  int N_DIN      = 8,
    parameter  int N_MC       = 8,
    parameter  int PT_PER_MC  = 8,
    localparam int N_SIG      = N_DIN + N_MC,
    localparam int N_COL      = 2 * N_SIG,
    localparam int N_PT       = N_MC * PT_PER_MC,
    localparam int ARRAY_BITS = N_PT * N_COL,
    localparam int CFG_W      = ARRAY_BITS + N_MC * MC_CTRL_BITS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg,
    input logic [N_MC-1:0]  io_out,
    input logic [N_MC-1:0]  io_oe,
    input logic [N_PT-1:0]  pterm,
    input logic [N_MC-1:0]  mc_val
);

    function automatic logic row_conflict(input logic [N_COL-1:0] row);
        logic hit;
        hit = 1'b0;
        for (int s = 0; s < N_SIG; s++) begin
            hit = hit | (row[2*s] & row[2*s+1]);
        end
        return hit;
    endfunction

    for (genvar m = 0; m < N_MC; m++) begin : g_mc_chk
        logic reg_m, pol_m, oet_m, ino_m;
        assign reg_m = cfg[ARRAY_BITS + m*MC_CTRL_BITS + 0];
        assign pol_m = cfg[ARRAY_BITS + m*MC_CTRL_BITS + 1];
        assign oet_m = cfg[ARRAY_BITS + m*MC_CTRL_BITS + 2];
        assign ino_m = cfg[ARRAY_BITS + m*MC_CTRL_BITS + 3];

        AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            reg_m |=> (!reg_m || io_out[m] == $past(mc_val[m]))); // R5

        AST_OE_FROM_TERM: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_m && oet_m && !ino_m) |-> io_oe[m] == pterm[m*PT_PER_MC]); // R9

        AST_OR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_m && !oet_m && pol_m && |pterm[m*PT_PER_MC +: PT_PER_MC]) |-> io_out[m]); // R3

        AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_m && ino_m) |-> !io_oe[m]); // R10
    end

    for (genvar t = 0; t < N_PT; t++) begin : g_pt_chk
        AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            row_conflict(cfg[t*N_COL +: N_COL]) |-> !pterm[t]); // R2

        AST_BLANK_TERM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[t*N_COL +: N_COL] == '0) |-> pterm[t]); // R1
    end

endmodule

bind pal_array pal_array_chk #(
    .N_DIN     (N_DIN),
    .N_MC      (N_MC),
    .PT_PER_MC (PT_PER_MC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg),
    .io_out (io_out),
    .io_oe  (io_oe),
    .pterm  (pterm),
    .mc_val (mc_val)
);

// File: tb/tb_pal_array.sv
module tb_pal_array;

    localparam int ARR = 2048;
    localparam int CW  = 2080;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg;
    logic [7:0]    in_pins;
    logic          oe_glob_n;
    logic [7:0]    io_in;
    logic [7:0]    io_out;
    logic [7:0]    io_oe;

    int            total = 0;
    int            bad = 0;
    logic [7:0]    q_m;
    logic [31:0]   lf = 32'h1234_ABCD;

    always #5 clk = ~clk;

    pal_array dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .in_pins   (in_pins),
        .oe_glob_n (oe_glob_n),
        .io_in     (io_in),
        .io_out    (io_out),
        .io_oe     (io_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
    endtask

    task automatic set_ctrl(input int m, input logic r, input logic p, input logic o, input logic i);
        cfg[ARR + 4*m +: 4] = {i, o, p, r};
    endtask

    task automatic blank_term(input int t);
        cfg[t*32 +: 32] = '0;
    endtask

    // Arithmetic model of the requirements.
    function automatic void model_eval(output logic [7:0] o, output logic [7:0] oe,
                                       output logic [7:0] nq);
        logic [15:0] sig;
        logic [63:0] p;
        sig[7:0] = in_pins;
        for (int m = 0; m < 8; m++) begin
            sig[8+m] = cfg[ARR+4*m] ? q_m[m] : io_in[m];
        end
        for (int t = 0; t < 64; t++) begin
            p[t] = 1'b1;
            for (int c = 0; c < 32; c++) begin
                if (cfg[t*32+c]) begin
                    p[t] = p[t] & ((c % 2 == 1) ? ~sig[c/2] : sig[c/2]);
                end
            end
        end
        for (int m = 0; m < 8; m++) begin
            logic r, pol, oet, ino, s, v;
            r   = cfg[ARR+4*m];
            pol = cfg[ARR+4*m+1];
            oet = cfg[ARR+4*m+2];
            ino = cfg[ARR+4*m+3];
            s = 1'b0;
            for (int k = 0; k < 8; k++) begin
                if (!(k == 0 && !r && oet)) s = s | p[m*8+k];
            end
            v = pol ? s : ~s;
            nq[m] = v;
            if (r) begin
                o[m]  = q_m[m];
                oe[m] = ~oe_glob_n;
            end else begin
                o[m]  = v;
                oe[m] = ino ? 1'b0 : (oet ? p[m*8] : 1'b1);
            end
        end
    endfunction

    // Called at a falling edge with inputs already applied.
    task automatic step(input string tag);
        logic [7:0] eo, eoe, enq;
        #2;
        model_eval(eo, eoe, enq);
        chk(tag, {24'd0, io_out}, {24'd0, eo});
        chk(tag, {24'd0, io_oe}, {24'd0, eoe});
        @(posedge clk);
        q_m = enq;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog R5 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg = '1;
        in_pins = '0;
        io_in = '0;
        oe_glob_n = 1'b0;
        q_m = '0;
        for (int m = 0; m < 8; m++) set_ctrl(m, 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R5 reset clears registers", {24'd0, io_out}, 32'd0);
        chk("R6 enable with oe_glob_n low", {24'd0, io_oe}, 32'hFF);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: blank-intact terms never fire.
        for (int m = 0; m < 8; m++) set_ctrl(m, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int v = 0; v < 256; v += 37) begin
            in_pins = v[7:0];
            #1 chk("R2 fully intact terms", {24'd0, io_out}, 32'd0);
        end
        blank_term(0);
        cfg[0] = 1'b1; cfg[1] = 1'b1; cfg[2] = 1'b1;
        in_pins = 8'hFF;
        #1 chk("R2 true and complement both intact", {31'd0, io_out[0]}, 32'd0);

        // R1: blank term is 1, then a two-literal term.
        blank_term(0);
        #1 chk("R1 term with no intact fuse", {31'd0, io_out[0]}, 32'd1);
        cfg[2*3] = 1'b1;
        cfg[2*5+1] = 1'b1;
        for (int v = 0; v < 256; v++) begin
            in_pins = v[7:0];
            #1 chk("R1 in3 and not in5", {31'd0, io_out[0]}, {31'd0, in_pins[3] & ~in_pins[5]});
        end
        chk("R9 enable is 1 without enable term", {31'd0, io_oe[0]}, 32'd1);

        // R8: combinational feedback is the pin input.
        blank_term(8);
        cfg[8*32 + 16] = 1'b1;
        in_pins = 8'h08;
        for (int b = 0; b < 2; b++) begin
            io_in[0] = b[0];
            #1 chk("R8 feedback from pin", {31'd0, io_out[1]}, {31'd0, b[0]});
        end

        // R3 / R4: eight single-literal terms in cell 2.
        for (int k = 0; k < 8; k++) begin
            blank_term(16 + k);
            cfg[(16+k)*32 + 2*k] = 1'b1;
        end
        for (int v = 0; v < 256; v++) begin
            in_pins = v[7:0];
            #1 chk("R3 eight-term OR", {31'd0, io_out[2]}, {31'd0, |in_pins});
        end
        set_ctrl(2, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int v = 0; v < 256; v++) begin
            in_pins = v[7:0];
            #1 chk("R4 inverted polarity", {31'd0, io_out[2]}, {31'd0, ~|in_pins});
        end

        // R9: first term of cell 3 is the enable.
        set_ctrl(3, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            blank_term(24 + k);
            cfg[(24+k)*32 + 2*k] = 1'b1;
        end
        for (int v = 0; v < 256; v++) begin
            in_pins = v[7:0];
            #1;
            chk("R9 enable term left out of sum", {31'd0, io_out[3]}, {31'd0, |in_pins[7:1]});
            chk("R9 enable from first term", {31'd0, io_oe[3]}, {31'd0, in_pins[0]});
        end

        // R10: released pin.
        set_ctrl(3, 1'b0, 1'b1, 1'b1, 1'b1);
        for (int v = 0; v < 256; v += 17) begin
            in_pins = v[7:0];
            #1;
            chk("R10 released pin not driven", {31'd0, io_oe[3]}, 32'd0);
            chk("R10 released pin still sums", {31'd0, io_out[3]}, {31'd0, |in_pins[7:1]});
        end

        // R5 / R7: cell 5 toggles through its own register.
        set_ctrl(5, 1'b1, 1'b1, 1'b0, 1'b0);
        blank_term(40);
        cfg[40*32 + 27] = 1'b1;
        set_ctrl(6, 1'b1, 1'b1, 1'b0, 1'b0);
        blank_term(48);
        cfg[48*32] = 1'b1;
        in_pins = 8'h00;
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk("R5 asynchronous clear", {30'd0, io_out[6:5]}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            io_in[5] = ~i[0];
            @(posedge clk);
            #2 chk("R7 register feedback ignores pin", {31'd0, io_out[5]}, {31'd0, ~i[0]});
        end

        // R5 hold between edges.
        @(negedge clk);
        in_pins[0] = 1'b1;
        #2 chk("R5 holds before edge", {31'd0, io_out[6]}, 32'd0);
        @(posedge clk);
        #2 chk("R5 loads on edge", {31'd0, io_out[6]}, 32'd1);
        @(negedge clk);
        in_pins[0] = 1'b0;
        #2 chk("R5 holds before edge", {31'd0, io_out[6]}, 32'd1);
        @(posedge clk);
        #2 chk("R5 loads on edge", {31'd0, io_out[6]}, 32'd0);

        // R6 and R10: registered cell ignores bits 2 and 3.
        set_ctrl(5, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            logic prev;
            @(negedge clk);
            oe_glob_n = i[0];
            prev = io_out[5];
            #1 chk("R6 enable follows oe_glob_n", {31'd0, io_oe[5]}, {31'd0, ~i[0]});
            @(posedge clk);
            #2 chk("R10 registered cell keeps all terms", {31'd0, io_out[5]}, {31'd0, ~prev});
        end

        // Pseudo-random sweeps across all modes.
        for (int n = 0; n < 4; n++) begin
            for (int t = 0; t < 64; t++) begin
                rnd();
                if (lf[2:0] == 3'd0) begin
                    cfg[t*32 +: 32] = '1;
                end else begin
                    for (int s = 0; s < 16; s++) begin
                        rnd();
                        cfg[t*32 + 2*s]     = (lf[3:0] == 4'd0);
                        cfg[t*32 + 2*s + 1] = (lf[3:0] == 4'd1);
                    end
                end
            end
            rnd();
            cfg[ARR +: 32] = lf;
            @(negedge clk);
            rst_n = 1'b0;
            q_m = '0;
            @(negedge clk);
            rst_n = 1'b1;
            for (int i = 0; i < 200; i++) begin
                rnd();
                in_pins = lf[7:0];
                io_in = lf[15:8];
                oe_glob_n = lf[16];
                step("R1 R3 R4 R5 R8 random sweep");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule